// File: doc/BRIEF.md
# Flash Read Accelerator with Code Prefetch and Data Line Buffer

This block sits between a 32-bit processor read port and a wide embedded flash array whose reads take a programmable number of wait states. Every flash access returns one aligned line, 128 bits by default. The accelerator keeps three line-wide buffers. Two of them serve instruction fetches and take turns: while one serves the current line, the other fetches the next sequential line. The third is a separate buffer for data reads. It holds the whole line that contains the last missed data word, so any later data read into that line is served without the flash.

The processor presents a request with a byte address and a code/data flag. It holds the request until a one-cycle `rd_ready` pulse returns the word, and then changes or drops the request. Only one flash access is in flight at any time. A demand miss that arrives while a prefetch is in flight waits for that access to end. Asserting `invalidate`, or changing the wait-state setting, empties all buffers and abandons any access in flight.

Top module: `flash_read_accel`

## Requirements
- R1: After reset, `rd_ready` and `flash_rd` are low.
- R2: A line holds 4 words. The word at byte offset 4k of a line sits at bits [32k+31:32k] of the line and is selected by address bits [3:2]. During an access, `flash_line_addr` carries address bits [19:4] of the missed line.
- R3: A miss that finds the flash idle keeps `rd_ready` low for `fws`+1 cycles after the request is sampled. The word follows in the next cycle, so the latency is `fws`+2 cycles.
- R4: A read that hits a buffer of its own kind returns its word with `rd_ready` one cycle after being sampled. `rd_ready` never rises without a request.
- R5: When a code fetch is served, the other code buffer fetches the next sequential line. A linear code stream therefore returns every word after the first in one cycle, for every `fws` from 0 to 3.
- R6: The data buffer keeps the whole missed line, so data reads anywhere in it hit, in any order. Data reads never hit the code buffers, and code fetches never hit the data buffer.
- R7: Only one flash access is outstanding. A data miss issued while a code prefetch is in flight starts when that prefetch ends, which gives a latency of 2·`fws`+2 when it follows straight after the code fetch that started the prefetch.
- R8: A cycle with `invalidate` high empties all buffers and abandons the access in flight. The next reads to those lines miss.
- R9: A change of `fws` has the same effect as `invalidate`. `rd_ready` stays low in the cycle after such a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_code | input | 1 | 1 = instruction fetch, 0 = data read |
| req_addr | input | 20 | Byte address of the requested word |
| fws | input | 2 | Flash wait states |
| invalidate | input | 1 | Empty all buffers |
| rd_data | output | 32 | Returned word |
| rd_ready | output | 1 | One-cycle pulse: `rd_data` is valid |
| flash_rd | output | 1 | A flash line access is in progress |
| flash_line_addr | output | 16 | Line address of the current flash access |
| flash_rdata | input | 128 | Line returned by the flash array |

## Verification
The assertions assume three things about the inputs. The processor holds a request stable until `rd_ready`, then moves on. The flash array presents the line for `flash_line_addr` without glitches. `fws` and `invalidate` change only while no request is waiting. The driver follows all three. It issues the next read in the same cycle it sees `rd_ready`, and it changes the wait states or pulses the invalidate only with `req_valid` low. The flash model in the bench computes every line from its address, so the expected words and latencies follow from the requirements alone.

// File: rtl/fra_pkg.sv
`timescale 1ns/1ps
package fra_pkg;
  // Destination of a flash line fill
  typedef enum logic [1:0] {
    DST_CODE0 = 2'd0,
    DST_CODE1 = 2'd1,
    DST_DATA  = 2'd2
  } fra_dst_e;
endpackage

// File: rtl/fra_line_buf.sv
`timescale 1ns/1ps
module fra_line_buf #(
  parameter int TAG_W  = 16,
  parameter int LINE_W = 128,
  parameter int WORD_W = 32,
  parameter int SEL_W  = $clog2(LINE_W / WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [SEL_W-1:0]  lk_sel,
  output logic              hit,
  output logic [WORD_W-1:0] word,
  output logic [TAG_W-1:0]  held_tag,
  output logic              held_valid
);
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_valid <= 1'b0;
      held_tag   <= '0;
    end else if (clear) begin
      held_valid <= 1'b0;
    end else if (wr_en) begin
      held_valid <= 1'b1;
      held_tag   <= wr_tag;
    end
  end

  // Line storage has no reset so it can map onto plain registers or RAM
  always_ff @(posedge clk) begin
    if (wr_en) line_q <= wr_line;
  end

  assign hit  = held_valid && (held_tag == lk_tag);
  assign word = line_q[lk_sel*WORD_W +: WORD_W];

  // R6: a fill leaves the line tagged and valid
  assert_fill_holds_line_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clear) |=> (held_valid && held_tag == $past(wr_tag)));

  // R8: a clear empties the buffer
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
    clear |=> !held_valid);
endmodule

// File: rtl/fra_flash_seq.sv
`timescale 1ns/1ps
module fra_flash_seq
  import fra_pkg::*;
#(
  parameter int TAG_W = 16,
  parameter int FWS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cancel,
  input  logic             start,
  input  logic [TAG_W-1:0] start_tag,
  input  fra_dst_e         start_dst,
  input  logic [FWS_W-1:0] fws,
  output logic             busy,
  output logic             done,
  output logic [TAG_W-1:0] cur_tag,
  output fra_dst_e         cur_dst
);
  logic [FWS_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      cur_tag <= '0;
      cur_dst <= DST_CODE0;
    end else if (cancel) begin
      busy <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      cnt     <= fws;
      cur_tag <= start_tag;
      cur_dst <= start_dst;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  // Checker: cycles spent in the access since it started
  logic [FWS_W-1:0] elapsed;
  always_ff @(posedge clk) begin
    if (rst || start) elapsed <= '0;
    else if (busy)    elapsed <= elapsed + 1'b1;
  end

  // R3: the line is taken only after fws+1 cycles of access
  assert_wait_states_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !cancel) |-> (elapsed == fws));

  // R7: a new access never starts over one still in progress
  assert_single_access_R7: assert property (@(posedge clk) disable iff (rst)
    start |-> (!busy || done || cancel));
endmodule

// File: rtl/flash_read_accel.sv
`timescale 1ns/1ps
module flash_read_accel
  import fra_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LINE_W = 128,
  parameter int WORD_W = 32,
  parameter int FWS_W  = 2
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    req_valid,
  input  logic                                    req_code,
  input  logic [ADDR_W-1:0]                       req_addr,
  input  logic [FWS_W-1:0]                        fws,
  input  logic                                    invalidate,
  output logic [WORD_W-1:0]                       rd_data,
  output logic                                    rd_ready,
  output logic                                    flash_rd,
  output logic [ADDR_W-$clog2(LINE_W/8)-1:0]      flash_line_addr,
  input  logic [LINE_W-1:0]                       flash_rdata
);
  localparam int OFS_W  = $clog2(LINE_W / 8);
  localparam int BSEL_W = $clog2(WORD_W / 8);
  localparam int TAG_W  = ADDR_W - OFS_W;
  localparam int SEL_W  = $clog2(LINE_W / WORD_W);
  localparam int NBUF   = 3;

  logic [TAG_W-1:0] req_tag, next_tag;
  logic [SEL_W-1:0] req_sel;
  assign req_tag  = req_addr[ADDR_W-1:OFS_W];
  assign req_sel  = req_addr[OFS_W-1:BSEL_W];
  assign next_tag = req_tag + TAG_W'(1);

  // Flush on invalidate or on a wait-state change
  logic [FWS_W-1:0] fws_q;
  logic             flush;
  always_ff @(posedge clk) begin
    if (rst) fws_q <= fws;
    else     fws_q <= fws;
  end
  assign flush = invalidate || (fws != fws_q);

  // Flash access sequencer
  logic             f_busy, f_done, start;
  logic [TAG_W-1:0] f_tag, start_tag;
  fra_dst_e         f_dst, start_dst;

  fra_flash_seq #(.TAG_W(TAG_W), .FWS_W(FWS_W)) u_seq (
    .clk(clk), .rst(rst), .cancel(flush), .start(start),
    .start_tag(start_tag), .start_dst(start_dst), .fws(fws),
    .busy(f_busy), .done(f_done), .cur_tag(f_tag), .cur_dst(f_dst)
  );

  // Line buffers: two for code, one for data
  logic [NBUF-1:0]   wr_en, hit;
  logic [WORD_W-1:0] bword      [NBUF];
  logic [TAG_W-1:0]  held_tag   [NBUF];
  logic              held_valid [NBUF];

  always_comb begin
    wr_en = '0;
    if (f_done && !flush) wr_en[f_dst] = 1'b1;
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    fra_line_buf #(.TAG_W(TAG_W), .LINE_W(LINE_W), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_buf (
      .clk(clk), .rst(rst), .clear(flush), .wr_en(wr_en[g]),
      .wr_tag(f_tag), .wr_line(flash_rdata),
      .lk_tag(req_tag), .lk_sel(req_sel),
      .hit(hit[g]), .word(bword[g]),
      .held_tag(held_tag[g]), .held_valid(held_valid[g])
    );
  end

  // Lookup and serve decision
  logic        buf_hit, bypass, same_kind, serve, in_flight, flash_free;
  logic        srv_code1, last_code1, pf_have, demand_start, pf_start;
  fra_dst_e    pf_dst, dem_dst;
  logic [WORD_W-1:0] sel_word;

  assign buf_hit    = req_code ? (hit[DST_CODE0] || hit[DST_CODE1]) : hit[DST_DATA];
  assign same_kind  = (f_dst == DST_DATA) == !req_code;
  assign bypass     = f_done && (f_tag == req_tag) && same_kind;
  assign in_flight  = f_busy && !f_done && (f_tag == req_tag) && same_kind;
  assign flash_free = !f_busy || f_done;
  assign serve      = req_valid && !flush && (buf_hit || bypass);

  assign srv_code1  = buf_hit ? hit[DST_CODE1] : (f_dst == DST_CODE1);
  assign pf_dst     = srv_code1 ? DST_CODE0 : DST_CODE1;
  assign dem_dst    = req_code ? (last_code1 ? DST_CODE0 : DST_CODE1) : DST_DATA;

  assign pf_have = (held_valid[pf_dst] && held_tag[pf_dst] == next_tag) ||
                   (f_busy && f_tag == next_tag && f_dst != DST_DATA);

  assign demand_start = req_valid && !flush && !buf_hit && !bypass && !in_flight && flash_free;
  assign pf_start     = serve && req_code && flash_free && !pf_have;
  assign start        = demand_start || pf_start;
  assign start_tag    = demand_start ? req_tag : next_tag;
  assign start_dst    = demand_start ? dem_dst : pf_dst;

  always_comb begin
    if (buf_hit) sel_word = req_code ? (hit[DST_CODE1] ? bword[DST_CODE1] : bword[DST_CODE0])
                                     : bword[DST_DATA];
    else         sel_word = flash_rdata[req_sel*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ready   <= 1'b0;
      rd_data    <= '0;
      last_code1 <= 1'b0;
    end else begin
      rd_ready <= serve;
      if (serve) rd_data <= sel_word;
      if (serve && req_code) last_code1 <= srv_code1;
    end
  end

  assign flash_rd        = f_busy;
  assign flash_line_addr = f_tag;

  // R4: every ready answers a request seen one cycle earlier
  assert_ready_has_request_R4: assert property (@(posedge clk) disable iff (rst)
    rd_ready |-> $past(req_valid));

  // R5: the two code buffers never hold the same line
  assert_code_bufs_distinct_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit[DST_CODE0], hit[DST_CODE1]}));

  // R9: nothing is returned in the cycle after a flush
  assert_flush_blocks_ready_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> !rd_ready);
endmodule

// File: tb/flash_read_accel_bench.sv
`timescale 1ns/1ps
module flash_read_accel_bench;
  localparam int ADDR_W = 20;
  localparam int LINE_W = 128;
  localparam int WORD_W = 32;
  localparam int FWS_W  = 2;
  localparam int TAG_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_code = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [FWS_W-1:0]  fws = 2'd3;
  logic              invalidate = 1'b0;
  logic [WORD_W-1:0] rd_data;
  logic              rd_ready;
  logic              flash_rd;
  logic [TAG_W-1:0]  flash_line_addr;
  logic [LINE_W-1:0] flash_rdata;

  always #2 clk = ~clk;

  flash_read_accel u_flash_read_accel (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
    .req_addr(req_addr), .fws(fws), .invalidate(invalidate),
    .rd_data(rd_data), .rd_ready(rd_ready), .flash_rd(flash_rd),
    .flash_line_addr(flash_line_addr), .flash_rdata(flash_rdata)
  );

  function automatic logic [31:0] word_at(input logic [19:0] a);
    logic [31:0] w;
    w = {14'd0, a[19:2]};
    return (w * 32'h9E3779B1) ^ 32'hA5C30F1E;
  endfunction

  // Flash array model: word k of a line lives at bits [32k+31:32k]
  always_comb begin
    for (int k = 0; k < 4; k++)
      flash_rdata[k*32 +: 32] = word_at({flash_line_addr, 2'(k), 2'b00});
  end

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Scoreboard
  logic [31:0] data_q[$];
  int          lat_q[$];
  int          iss_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    if (!rst && rd_ready) begin
      if (data_q.size() == 0) begin
        check(1'b0, "R4", "ready without request", 32'd1, 32'd0);
      end else begin
        logic [31:0] ed;
        int el, ei;
        string et;
        ed = data_q.pop_front();
        el = lat_q.pop_front();
        ei = iss_q.pop_front();
        et = tag_q.pop_front();
        check(rd_data == ed, et, "data", rd_data, ed);
        check((cyc - ei) == el, et, "latency", 32'(cyc - ei), 32'(el));
      end
    end
  end

  // Driver: called at a falling edge, returns at the falling edge with ready seen
  task automatic rd(input logic [19:0] a, input bit code, input int lat,
                    input string rq, input bit probe);
    int waited;
    req_valid = 1'b1;
    req_addr  = a;
    req_code  = code;
    data_q.push_back(word_at(a));
    lat_q.push_back(lat);
    iss_q.push_back(cyc);
    tag_q.push_back(rq);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
      if (probe && waited == 1) begin
        check(flash_rd == 1'b1, "R2", "flash access active", 32'(flash_rd), 32'd1);
        check(flash_line_addr == a[19:4], "R2", "flash line address",
              32'(flash_line_addr), 32'(a[19:4]));
      end
      if (waited > 100) begin
        check(1'b0, rq, "request timeout", 32'(waited), 32'(lat));
        break;
      end
    end while (!rd_ready);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic set_fws(input logic [1:0] v);
    fws = v;
    idle(2);
  endtask

  task automatic pulse_inval();
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
  endtask

  // Linear code stream from a cold line: R5
  task automatic stream(input logic [19:0] base, input int nwords);
    for (int i = 0; i < nwords; i++)
      rd(base + 20'(4 * i), 1'b1, (i == 0) ? int'(fws) + 2 : 1, "R5", 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R3", "watchdog expired", 32'd0, 32'd1);
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    check(rd_ready == 1'b0, "R1", "ready after reset", 32'(rd_ready), 32'd0);
    check(flash_rd == 1'b0, "R1", "flash idle after reset", 32'(flash_rd), 32'd0);

    // R2/R3: cold data miss at line 0x12, word 2
    rd(20'h00128, 1'b0, 5, "R3", 1'b1);
    // R6/R4: data hits in the same line, out of order
    rd(20'h0012C, 1'b0, 1, "R6", 1'b0);
    rd(20'h00120, 1'b0, 1, "R6", 1'b0);
    rd(20'h00124, 1'b0, 1, "R4", 1'b0);
    // R6: code fetch does not hit the data buffer
    rd(20'h00120, 1'b1, 5, "R6", 1'b0);
    rd(20'h00124, 1'b0, 1, "R6", 1'b0);
    idle(6);
    // R5: the next line was prefetched into the other code buffer
    rd(20'h00130, 1'b1, 1, "R5", 1'b0);
    rd(20'h00134, 1'b1, 1, "R4", 1'b0);

    // R5: long stream at fws = 3
    idle(6);
    stream(20'h00400, 64);

    // R9: wait-state change flushes, then streams at each setting
    idle(6);
    rd(20'h00124, 1'b0, 1, "R9", 1'b0);
    set_fws(2'd0);
    rd(20'h00124, 1'b0, 2, "R9", 1'b0);
    idle(6);
    stream(20'h01000, 16);
    set_fws(2'd1);
    stream(20'h02000, 16);
    set_fws(2'd2);
    stream(20'h03000, 16);
    set_fws(2'd3);

    // R7: data miss waits for the prefetch in flight
    idle(6);
    rd(20'h0500C, 1'b1, 5, "R7", 1'b0);
    rd(20'h06008, 1'b0, 2 * int'(fws) + 2, "R7", 1'b0);
    rd(20'h05010, 1'b1, 1, "R7", 1'b0);

    // R8: invalidate empties the buffers
    idle(6);
    rd(20'h06004, 1'b0, 1, "R8", 1'b0);
    pulse_inval();
    rd(20'h06004, 1'b0, 5, "R8", 1'b0);
    rd(20'h05014, 1'b1, 5, "R8", 1'b0);

    // R8: invalidate abandons the prefetch in flight
    idle(6);
    rd(20'h0700C, 1'b1, 5, "R8", 1'b0);
    pulse_inval();
    rd(20'h07010, 1'b1, 5, "R8", 1'b0);

    idle(4);
    check(data_q.size() == 0, "R4", "responses outstanding", 32'(data_q.size()), 32'd0);
    report();
  end
endmodule